// File: doc/BRIEF.md
# Real-Time Counter with Posted Time, Shadow Seconds and Seconds Alarm

The block keeps wall-clock time from a 32 kHz tick strobe that arrives in the bus clock domain. Internally it counts milliseconds (0 to 999) and a 32-bit seconds value. Milliseconds advance through a fractional accumulator, so that exactly 1000 millisecond steps occur in every `TICK_HZ` ticks. Software does not see the internal counters directly. Every eighth tick the block posts them into bus-visible copies, and it holds a busy flag high from that posting until the next tick.

Reads are accepted at any time and return data one cycle after the request. A write that arrives while busy is high is discarded, and it sets a sticky error flag. A read of the milliseconds register captures the posted seconds into a shadow register. A later read of the shadow therefore gives a seconds value that belongs with the milliseconds just read. A seconds alarm comparator sets a status bit that is cleared by writing a one to it. The interrupt output is that bit gated by a mask bit.

Register word addresses are 0 seconds, 1 milliseconds (read only), 2 shadow seconds (read only), 3 alarm, 4 status, 5 mask and 6 control/busy.

Top module: `rtc_shadow_timer`

## Requirements
- R1: The internal milliseconds count stays within 0..999. After n ticks from a seconds load it equals floor(n*1000/TICK_HZ) mod 1000.
- R2: When milliseconds step past 999 they become 0 in the same update that increments seconds by one.
- R3: Bit 0 of register 6 reads 1 from the posting that follows every eighth tick since reset until the next tick, and reads 0 at all other times.
- R4: Registers 0 and 1 return the values copied at the most recent posting, or at the most recent seconds load, and they can be read while busy is 1.
- R5: A write made while busy is 1 changes no register and sets bit 1 of register 6. Writing 1 to that bit while busy is 0 clears it.
- R6: A read of register 1 copies the posted seconds into register 2. No other event changes register 2.
- R7: When the internal seconds become equal to register 3, bit 0 of register 4 is set.
- R8: The irq output is registered and is high only when bit 0 of register 4 and bit 0 of register 5 are both 1.
- R9: Writing a 1 at bit 0 of register 4 (for example all ones) clears it. Writing a 0 there leaves it unchanged.
- R10: A write to register 0 loads the internal and posted seconds. It also clears the internal and posted milliseconds and the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe per 32 kHz period |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The assertions check the following on every cycle:
- the milliseconds range and the coupled wrap into seconds;
- the way busy is held and released between ticks;
- that a write made while busy leaves the alarm unchanged and raises the error flag;
- that the shadow holds its value when no milliseconds read occurs;
- the mask gating and write-one-to-clear on the status bit.

Only the bench scenarios show the values themselves:
- the exact accumulator values after a long run of ticks;
- that the posted registers lag the internal count until a posting;
- that the shadow stays coherent across a seconds boundary;
- that the alarm fires on the tick that reaches the target second, with the mask either open or closed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 3;
  typedef enum logic [REG_AW-1:0] {
    A_SEC    = 3'd0,
    A_MSEC   = 3'd1,
    A_SHADOW = 3'd2,
    A_ALARM  = 3'd3,
    A_STATUS = 3'd4,
    A_MASK   = 3'd5,
    A_CTRL   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICK_HZ    = 32768,
  parameter int MS_PER_SEC = 1000,
  parameter int POST_TICKS = 8,
  parameter int DATA_W     = 32,
  localparam int ACC_W = $clog2(TICK_HZ) + 1,
  localparam int MS_W  = $clog2(MS_PER_SEC),
  localparam int PH_W  = (POST_TICKS > 1) ? $clog2(POST_TICKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] sec,
  output logic [MS_W-1:0]   ms,
  output logic              sec_chg,
  output logic              post
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic [PH_W-1:0]  phase;
  logic             ms_step;
  logic             ms_last;

  always_comb begin
    acc_sum = acc + ACC_W'(MS_PER_SEC);
    ms_step = tick && (acc_sum >= ACC_W'(TICK_HZ));
    ms_last = (ms == MS_W'(MS_PER_SEC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      ms      <= '0;
      sec     <= '0;
      sec_chg <= 1'b0;
    end else begin
      sec_chg <= 1'b0;
      if (load) begin
        acc     <= '0;
        ms      <= '0;
        sec     <= load_val;
        sec_chg <= 1'b1;
      end else if (tick) begin
        if (ms_step) begin
          acc <= acc_sum - ACC_W'(TICK_HZ);
          if (ms_last) begin
            ms      <= '0;
            sec     <= sec + 1'b1;
            sec_chg <= 1'b1;
          end else begin
            ms <= ms + 1'b1;
          end
        end else begin
          acc <= acc_sum;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      post  <= 1'b0;
    end else begin
      post <= tick && (phase == PH_W'(POST_TICKS - 1));
      if (tick) phase <= (phase == PH_W'(POST_TICKS - 1)) ? '0 : phase + 1'b1;
    end
  end

  // R1: milliseconds never leave their range
  assert_ms_range_R1: assert property (@(posedge clk) disable iff (rst)
    ms < MS_W'(MS_PER_SEC));

  // R2: wrap of milliseconds carries into seconds in the same update
  assert_ms_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (ms_step && ms_last && !load) |=> (ms == '0 && sec == $past(sec) + 1'b1));
endmodule

// File: rtl/rtc_post.sv
module rtc_post #(
  parameter int MS_PER_SEC = 1000,
  parameter int DATA_W     = 32,
  localparam int MS_W = $clog2(MS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              post,
  input  logic [DATA_W-1:0] sec,
  input  logic [MS_W-1:0]   ms,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              ms_rd,
  output logic              busy,
  output logic [DATA_W-1:0] vis_sec,
  output logic [MS_W-1:0]   vis_ms,
  output logic [DATA_W-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      vis_sec <= '0;
      vis_ms  <= '0;
      shadow  <= '0;
    end else begin
      if (post)      busy <= 1'b1;
      else if (tick) busy <= 1'b0;
      if (load) begin
        vis_sec <= load_val;
        vis_ms  <= '0;
      end else if (post) begin
        vis_sec <= sec;
        vis_ms  <= ms;
      end
      if (ms_rd) shadow <= vis_sec;
    end
  end

  // R3: busy persists until a tick ends the posting window
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !post) |=> busy);
  assert_busy_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !post) |=> !busy);

  // R6: shadow changes only on a milliseconds read
  assert_shadow_stable_R6: assert property (@(posedge clk) disable iff (rst)
    !ms_rd |=> $stable(shadow));
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sec,
  input  logic              sec_chg,
  input  logic              alarm_we,
  input  logic [DATA_W-1:0] alarm_wd,
  input  logic              mask_we,
  input  logic              mask_bit,
  input  logic              clr_we,
  input  logic              clr_bit,
  output logic [DATA_W-1:0] alarm,
  output logic              status,
  output logic              mask,
  output logic              irq
);
  logic hit;
  assign hit = sec_chg && (sec == alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm  <= '0;
      status <= 1'b0;
      mask   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (alarm_we) alarm <= alarm_wd;
      if (mask_we)  mask  <= mask_bit;
      if (hit)                  status <= 1'b1;
      else if (clr_we && clr_bit) status <= 1'b0;
      irq <= status && mask;
    end
  end

  // R8: irq stays low unless both status and mask were set
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !(status && mask) |=> !irq);

  // R9: write-one clears a pending status when no new hit arrives
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_bit && !hit) |=> !status);
endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
  import rtc_pkg::*;
#(
  parameter int TICK_HZ    = 32768,
  parameter int MS_PER_SEC = 1000,
  parameter int POST_TICKS = 8,
  parameter int DATA_W     = 32,
  localparam int MS_W = $clog2(MS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] sec, vis_sec, shadow, alarm;
  logic [MS_W-1:0]   ms, vis_ms;
  logic              sec_chg, post, busy, status, mask, werr;
  logic              wr_ok, ld_sec, ms_rd;

  assign wr_ok  = wr_en && !busy;
  assign ld_sec = wr_ok && (addr == A_SEC);
  assign ms_rd  = rd_en && (addr == A_MSEC);

  rtc_timebase #(.TICK_HZ(TICK_HZ), .MS_PER_SEC(MS_PER_SEC),
                 .POST_TICKS(POST_TICKS), .DATA_W(DATA_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .load(ld_sec), .load_val(wdata),
    .sec(sec), .ms(ms), .sec_chg(sec_chg), .post(post));

  rtc_post #(.MS_PER_SEC(MS_PER_SEC), .DATA_W(DATA_W)) u_post (
    .clk(clk), .rst(rst), .tick(tick), .post(post), .sec(sec), .ms(ms),
    .load(ld_sec), .load_val(wdata), .ms_rd(ms_rd), .busy(busy),
    .vis_sec(vis_sec), .vis_ms(vis_ms), .shadow(shadow));

  rtc_irq #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .sec(sec), .sec_chg(sec_chg),
    .alarm_we(wr_ok && addr == A_ALARM), .alarm_wd(wdata),
    .mask_we(wr_ok && addr == A_MASK), .mask_bit(wdata[0]),
    .clr_we(wr_ok && addr == A_STATUS), .clr_bit(wdata[0]),
    .alarm(alarm), .status(status), .mask(mask), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      werr <= 1'b0;
    end else if (wr_en && busy) begin
      werr <= 1'b1;
    end else if (wr_ok && addr == A_CTRL && wdata[1]) begin
      werr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_SEC:    rdata <= vis_sec;
        A_MSEC:   rdata <= DATA_W'(vis_ms);
        A_SHADOW: rdata <= shadow;
        A_ALARM:  rdata <= alarm;
        A_STATUS: rdata <= DATA_W'(status);
        A_MASK:   rdata <= DATA_W'(mask);
        A_CTRL:   rdata <= DATA_W'({werr, busy});
        default:  rdata <= '0;
      endcase
    end
  end

  // R5: a write during busy flags an error and leaves the alarm untouched
  assert_busy_write_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> werr);
  assert_busy_write_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> $stable(alarm));
endmodule

// File: tb/rtc_shadow_timer_tb.sv
module rtc_shadow_timer_tb;
  localparam int HZ = 2048;
  localparam int MSPS = 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  longint t_tot = 0, nt = 0, base = 0;
  logic [31:0] m_vsec = 0, m_vms = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  rtc_shadow_timer #(.TICK_HZ(HZ), .MS_PER_SEC(MSPS)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the result appears
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard empty actual=%0h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (3) @(negedge clk);
      t_tot++; nt++;
      if (t_tot % 8 == 0) begin
        m_vsec = 32'(base + nt / HZ);
        m_vms  = 32'((nt * MSPS / HZ) % MSPS);
      end
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_sec(input logic [31:0] v);
    bus_wr(3'd0, v);
    base = v; nt = 0; m_vsec = v; m_vms = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    bus_rd(3'd0, 0, "reset SEC R4");
    bus_rd(3'd1, 0, "reset MS R1");
    bus_rd(3'd6, 0, "reset CTRL R3");
    bus_rd(3'd4, 0, "reset STATUS R7");
    check("reset irq R8", 32'(irq), 0);

    run_ticks(5);
    bus_rd(3'd1, 0, "MS not yet posted R4");
    bus_rd(3'd6, 0, "not busy before 8th tick R3");
    run_ticks(3);
    bus_rd(3'd6, 32'h1, "busy after 8th tick R3");
    bus_rd(3'd1, m_vms, "MS posted, read during busy R4 R1");
    check("model ms after 8 ticks R1", m_vms, 3);

    // write during busy
    bus_wr(3'd3, 32'h55);
    bus_rd(3'd3, 0, "alarm write ignored while busy R5");
    bus_rd(3'd6, 32'h3, "error flag set R5");
    run_ticks(1);
    bus_rd(3'd6, 32'h2, "busy ends on next tick R3");
    bus_wr(3'd6, 32'h2);
    bus_rd(3'd6, 0, "error flag cleared R5");

    // load seconds and shadow
    load_sec(100);
    bus_rd(3'd0, 100, "SEC load R10");
    bus_rd(3'd1, 0, "MS cleared on load R10");
    bus_wr(3'd3, 101);
    bus_wr(3'd5, 1);
    bus_rd(3'd1, 0, "MS read R6");
    bus_rd(3'd2, 100, "shadow latched R6");

    run_ticks(2047);
    bus_rd(3'd1, 999, "MS at 2047 ticks R1");
    check("irq before alarm R8", 32'(irq), 0);
    run_ticks(1);
    check("irq on alarm R7 R8", 32'(irq), 1);
    bus_rd(3'd4, 1, "status on alarm R7");
    bus_rd(3'd0, 100, "SEC not posted yet R4");
    bus_rd(3'd2, 100, "shadow unchanged without MS read R6");
    run_ticks(7);
    bus_rd(3'd0, 101, "seconds carried R2");
    bus_rd(3'd1, 3, "MS wrapped past 999 R2");
    run_ticks(1);

    bus_wr(3'd4, 32'h0);
    bus_rd(3'd4, 1, "write 0 keeps status R9");
    bus_wr(3'd4, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("irq cleared R9", 32'(irq), 0);
    bus_rd(3'd4, 0, "status cleared R9");

    // alarm with mask closed
    load_sec(200);
    bus_wr(3'd3, 201);
    bus_wr(3'd5, 0);
    run_ticks(HZ);
    bus_rd(3'd4, 1, "status set with mask off R7");
    check("irq masked R8", 32'(irq), 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule